// File: doc/BRIEF.md
# Fragmented CAN Message Reassembly Engine

This block rebuilds one long message from a stream of CAN data frames that acceptance filtering has already matched to a single message object. The first payload byte of every frame is fragmentation control. It is decoded and then dropped. The other payload bytes are written one per clock, through a byte-wide write port, into a receive buffer at consecutive addresses. The block keeps a running count of the stored bytes. It checks that frames arrive in order, and it reports the end of a message, a full buffer, or an ordering fault on three single-cycle interrupt lines.

Software picks one of four protocol modes and loads the start pointer, the buffer limit and the fragment count register with a one-cycle load pulse. The fragment count register holds the expected sequence number or toggle state. When a message completes or the buffer fills, the byte count is written to buffer offset 0. Offset 0 is therefore kept free for the count in every mode. In sequence mode a first frame also writes 00h there at the start, to mark that a message is in progress.

Top module: `frag_reasm`

## Requirements
- R1: After a synchronous reset, `frm_ready` is 1, `wr_en` and all three interrupts are 0, and `sts_count` is 0.
- R2: Byte 0 of `frm_data` (bits [7:0]) is the control byte and is never written. Bytes 1 to DLC-1 go to consecutive addresses starting at the pointer, one byte per cycle, and the count rises by one per byte. A DLC above 8 is treated as 8.
- R3: A frame with DLC 0 or 1 writes nothing, raises nothing and leaves the expected sequence or toggle state unchanged.
- R4: In sequence mode (`cfg_mode` = 01), control bits [7:6] give the frame type: 00 first, 01 middle, 10 last, 11 reserved. Bits [5:0] are the sequence number. A reserved frame is ignored. A first frame is not checked. It writes 00h to address 0, sets the pointer to 1 and the count to 0, and makes its own sequence number plus one (mod 64) the expected value.
- R5: In sequence mode, a middle or last frame must carry the expected sequence number. After that frame, the expected value becomes that number plus one, wrapping from 63 to 0.
- R6: In toggle mode (`cfg_mode` = 10), control bit 4 must equal the expected toggle state (bit 0 of the fragment count register), which then inverts. Control bit 0 marks the last frame. No frame is treated as a message start.
- R7: In no-last mode (`cfg_mode` = 11), control bits [5:0] of every frame, the first one included, must equal the expected sequence number, which then increments mod 64. No frame ever completes a message.
- R8: In plain mode (`cfg_mode` = 00), no ordering check is made and no message completes. Payload bytes are simply appended.
- R9: After the last byte of a last frame, the next cycle writes the count to address 0 and pulses `irq_done`.
- R10: When a stored byte brings the pointer equal to `cfg_limit`, and that byte does not complete a message, the next cycle writes the count to address 0 and pulses `irq_full`. The rest of that frame and all later frames are dropped until a load. If the limit is reached on the byte that completes a message, completion wins.
- R11: A frame that fails its ordering check writes nothing. It sets the count to 0, returns the pointer to the loaded start address, and pulses `irq_err`.
- R12: A `cfg_load` pulse loads the pointer and the start address from `cfg_ptr` and the expected value from `cfg_fcr`. It clears the count and ends any dropping caused by a full buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Protocol mode: 00 plain, 01 sequence, 10 toggle, 11 no-last |
| cfg_load | input | 1 | One-cycle load of pointer, start address and expected value |
| cfg_ptr | input | ADDR_W | Start address loaded by `cfg_load` |
| cfg_fcr | input | 6 | Expected sequence number, or toggle state in bit 0 |
| cfg_limit | input | ADDR_W | Buffer limit address |
| frm_valid | input | 1 | Frame present |
| frm_ready | output | 1 | Engine idle; frame taken when valid and ready |
| frm_dlc | input | 4 | Data length code of the frame |
| frm_data | input | 64 | Frame payload, byte k in bits [8k+7:8k] |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | ADDR_W | Buffer write address |
| wr_data | output | 8 | Buffer write data |
| irq_done | output | 1 | Message complete pulse |
| irq_full | output | 1 | Buffer full pulse |
| irq_err | output | 1 | Fragmentation error pulse |
| sts_count | output | ADDR_W | Running stored byte count |

## Verification
The bench builds the engine with a 6-bit address, so the whole 64-byte buffer can be mirrored and compared byte by byte. Small limits such as 8 and 10 make the buffer-full case, and the case where the limit and completion land on the same byte, reachable within a few frames. Payload bytes are numbered as a base value plus their position, so every expected buffer address and value follows by arithmetic from the frame sequence. Sequence numbers run across the 63-to-0 wrap, the toggle state runs through several inversions, and short and over-long DLC values are included.

// File: rtl/frag_pkg.sv
package frag_pkg;
  localparam int SEQ_W = 6;

  typedef enum logic [1:0] {
    MODE_PLAIN  = 2'b00,
    MODE_SEQ    = 2'b01,
    MODE_TGL    = 2'b10,
    MODE_NOLAST = 2'b11
  } frag_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_CNT  = 2'd2
  } eng_state_e;

  typedef logic [7:0][7:0] pay_t;

  typedef struct packed {
    logic             skip;
    logic             err;
    logic             first;
    logic             last;
    logic [SEQ_W-1:0] nxt;
    logic [2:0]       nbytes;
  } frag_dec_t;
endpackage

// File: rtl/frag_decode.sv
module frag_decode
  import frag_pkg::*;
(
  input  frag_mode_e       mode,
  input  logic [7:0]       fbyte,
  input  logic [3:0]       dlc,
  input  logic [SEQ_W-1:0] expect_q,
  output frag_dec_t        dec
);
  logic [3:0]       dlc_c;
  logic [1:0]       ftype;
  logic [SEQ_W-1:0] seq;

  always_comb begin
    dlc_c = (dlc > 4'd8) ? 4'd8 : dlc;
    ftype = fbyte[7:6];
    seq   = fbyte[SEQ_W-1:0];
    dec        = '0;
    dec.nxt    = expect_q;
    dec.nbytes = (dlc_c == 4'd0) ? 3'd0 : 3'(dlc_c - 4'd1);
    case (mode)
      MODE_SEQ: begin
        if (ftype == 2'b11) begin
          dec.skip = 1'b1;
        end else if (ftype == 2'b00) begin
          dec.first = 1'b1;
          dec.nxt   = seq + 1'b1;
        end else begin
          dec.err  = (seq != expect_q);
          dec.nxt  = expect_q + 1'b1;
          dec.last = (ftype == 2'b10);
        end
      end
      MODE_TGL: begin
        dec.err  = (fbyte[4] != expect_q[0]);
        dec.nxt  = {expect_q[SEQ_W-1:1], ~expect_q[0]};
        dec.last = fbyte[0];
      end
      MODE_NOLAST: begin
        dec.err = (seq != expect_q);
        dec.nxt = expect_q + 1'b1;
      end
      default: ;
    endcase
    if (dec.nbytes == 3'd0) dec.skip = 1'b1;
  end
endmodule

// File: rtl/frag_engine.sv
module frag_engine
  import frag_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_ptr,
  input  logic [SEQ_W-1:0]  cfg_fcr,
  input  logic [ADDR_W-1:0] cfg_limit,
  input  logic              acc,
  input  frag_dec_t         dec,
  input  pay_t              pay_in,
  output logic              ready,
  output logic [SEQ_W-1:0]  expect_q,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              irq_done,
  output logic              irq_full,
  output logic              irq_err,
  output logic [ADDR_W-1:0] count
);
  eng_state_e        state;
  logic [ADDR_W-1:0] ptr, start;
  logic              halted, lastf, kind_done;
  logic [2:0]        idx, nb;
  pay_t              pay;
  logic              fin, hit_limit;

  always_comb begin
    fin       = (idx == nb - 3'd1);
    hit_limit = (ADDR_W'(ptr + 1'b1) == cfg_limit);
  end

  assign ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ptr       <= '0;
      start     <= '0;
      count     <= '0;
      expect_q  <= '0;
      halted    <= 1'b0;
      lastf     <= 1'b0;
      kind_done <= 1'b0;
      idx       <= '0;
      nb        <= '0;
      pay       <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      irq_done  <= 1'b0;
      irq_full  <= 1'b0;
      irq_err   <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      irq_done <= 1'b0;
      irq_full <= 1'b0;
      irq_err  <= 1'b0;
      if (cfg_load) begin
        ptr      <= cfg_ptr;
        start    <= cfg_ptr;
        count    <= '0;
        expect_q <= cfg_fcr;
        halted   <= 1'b0;
        state    <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (acc && !dec.skip && !halted) begin
              if (dec.err) begin
                irq_err <= 1'b1;
                ptr     <= start;
                count   <= '0;
              end else begin
                expect_q <= dec.nxt;
                pay      <= pay_in;
                nb       <= dec.nbytes;
                idx      <= '0;
                lastf    <= dec.last;
                state    <= ST_DATA;
                if (dec.first) begin
                  wr_en   <= 1'b1;
                  wr_addr <= '0;
                  wr_data <= 8'h00;
                  ptr     <= ADDR_W'(1);
                  count   <= '0;
                end
              end
            end
          end
          ST_DATA: begin
            wr_en   <= 1'b1;
            wr_addr <= ptr;
            wr_data <= pay[idx];
            ptr     <= ptr + 1'b1;
            count   <= count + 1'b1;
            idx     <= idx + 3'd1;
            if (fin && lastf) begin
              kind_done <= 1'b1;
              state     <= ST_CNT;
            end else if (hit_limit) begin
              kind_done <= 1'b0;
              halted    <= 1'b1;
              state     <= ST_CNT;
            end else if (fin) begin
              state <= ST_IDLE;
            end
          end
          ST_CNT: begin
            wr_en   <= 1'b1;
            wr_addr <= '0;
            wr_data <= 8'(count);
            if (kind_done) irq_done <= 1'b1;
            else           irq_full <= 1'b1;
            state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/frag_reasm.sv
module frag_reasm
  import frag_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_ptr,
  input  logic [5:0]        cfg_fcr,
  input  logic [ADDR_W-1:0] cfg_limit,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [3:0]        frm_dlc,
  input  logic [63:0]       frm_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              irq_done,
  output logic              irq_full,
  output logic              irq_err,
  output logic [ADDR_W-1:0] sts_count
);
  frag_dec_t        dec;
  pay_t             pay_in;
  logic [SEQ_W-1:0] expect_q;

  for (genvar k = 0; k < 7; k++) begin : g_pay
    assign pay_in[k] = frm_data[8*(k+1) +: 8];
  end
  assign pay_in[7] = 8'h00;

  frag_decode u_dec (
    .mode     (frag_mode_e'(cfg_mode)),
    .fbyte    (frm_data[7:0]),
    .dlc      (frm_dlc),
    .expect_q (expect_q),
    .dec      (dec)
  );

  frag_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .cfg_load  (cfg_load),
    .cfg_ptr   (cfg_ptr),
    .cfg_fcr   (cfg_fcr),
    .cfg_limit (cfg_limit),
    .acc       (frm_valid && frm_ready),
    .dec       (dec),
    .pay_in    (pay_in),
    .ready     (frm_ready),
    .expect_q  (expect_q),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .irq_done  (irq_done),
    .irq_full  (irq_full),
    .irq_err   (irq_err),
    .count     (sts_count)
  );
endmodule

// File: rtl/frag_reasm_chk.sv
module frag_reasm_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cfg_mode,
  input logic              frm_ready,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              irq_done,
  input logic              irq_full,
  input logic              irq_err,
  input logic [ADDR_W-1:0] sts_count
);
  p_irq_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_done, irq_full, irq_err}));

  p_count_to_base_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_done || irq_full) |-> (wr_en && wr_addr == '0));

  p_err_no_store_r11: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> (!wr_en && sts_count == '0));

  p_plain_no_err_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_mode) == 2'b00) |-> !irq_err);

  p_ready_after_done_r9: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> frm_ready);
endmodule

bind frag_reasm frag_reasm_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_mode  (cfg_mode),
  .frm_ready (frm_ready),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .irq_done  (irq_done),
  .irq_full  (irq_full),
  .irq_err   (irq_err),
  .sts_count (sts_count)
);

// File: tb/frag_reasm_tb.sv
`timescale 1ns/1ps
module frag_reasm_tb;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cfg_mode = 2'b01;
  logic          cfg_load = 1'b0;
  logic [AW-1:0] cfg_ptr = '0;
  logic [5:0]    cfg_fcr = '0;
  logic [AW-1:0] cfg_limit = '1;
  logic          frm_valid = 1'b0;
  logic          frm_ready;
  logic [3:0]    frm_dlc = '0;
  logic [63:0]   frm_data = '0;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          irq_done, irq_full, irq_err;
  logic [AW-1:0] sts_count;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0]    tmem [64];
  logic [AW-1:0] wlog_a [1024];
  logic [7:0]    wlog_d [1024];
  int nwr = 0, n_done = 0, n_full = 0, n_err = 0;

  always #10 clk = ~clk;

  frag_reasm #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_load(cfg_load),
    .cfg_ptr(cfg_ptr), .cfg_fcr(cfg_fcr), .cfg_limit(cfg_limit),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_dlc(frm_dlc),
    .frm_data(frm_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_done(irq_done), .irq_full(irq_full), .irq_err(irq_err),
    .sts_count(sts_count)
  );

  initial for (int i = 0; i < 64; i++) tmem[i] = 8'hEE;

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        tmem[wr_addr] = wr_data;
        wlog_a[nwr % 1024] = wr_addr;
        wlog_d[nwr % 1024] = wr_data;
        nwr = nwr + 1;
      end
      if (irq_done) n_done = n_done + 1;
      if (irq_full) n_full = n_full + 1;
      if (irq_err)  n_err  = n_err + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    #2;
  endtask

  task automatic load(input logic [1:0] m, input int p, input int f, input int lim);
    @(negedge clk);
    cfg_mode  = m;
    cfg_ptr   = AW'(p);
    cfg_fcr   = 6'(f);
    cfg_limit = AW'(lim);
    cfg_load  = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    #2;
  endtask

  task automatic send(input logic [7:0] fb, input logic [3:0] dlc, input logic [7:0] base);
    @(negedge clk);
    while (!frm_ready) @(negedge clk);
    frm_data[7:0] = fb;
    for (int k = 1; k < 8; k++) frm_data[8*k +: 8] = base + 8'(k);
    frm_dlc   = dlc;
    frm_valid = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
    settle();
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int m, d0, f0, e0, w0, exp_v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    // R1 reset state
    chk("R1 ready", int'(frm_ready), 1);
    chk("R1 wr_en", int'(wr_en), 0);
    chk("R1 irqs", int'({irq_done, irq_full, irq_err}), 0);
    chk("R1 count", int'(sts_count), 0);

    // R4 R2 R5 R9: sequence mode three-frame message
    load(2'b01, 20, 0, 63);
    m = nwr; d0 = n_done;
    send(8'h00, 4'd8, 8'h10);
    chk("R4 semaphore addr", int'(wlog_a[m]), 0);
    chk("R4 semaphore data", int'(wlog_d[m]), 0);
    send(8'h41, 4'd5, 8'h20);
    send(8'h82, 4'd3, 8'h30);
    for (int a = 1; a <= 13; a++) begin
      exp_v = (a <= 7) ? 8'h10 + a : (a <= 11) ? 8'h20 + a - 7 : 8'h30 + a - 11;
      chk("R2 payload", int'(tmem[a]), exp_v);
    end
    chk("R2 control byte not stored", int'(tmem[14]), 8'hEE);
    chk("R9 count at base", int'(tmem[0]), 13);
    chk("R9 done pulse", n_done - d0, 1);
    chk("R9 status count", int'(sts_count), 13);

    // R5 wrap 63 -> 0
    e0 = n_err; d0 = n_done;
    send(8'h3F, 4'd2, 8'h40);
    send(8'h40, 4'd2, 8'h50);
    send(8'h81, 4'd2, 8'h60);
    chk("R5 wrap no error", n_err - e0, 0);
    chk("R5 wrap done", n_done - d0, 1);
    chk("R5 wrap data", int'(tmem[2]), 8'h51);
    chk("R5 wrap count", int'(tmem[0]), 3);

    // R5 R11: out-of-order sequence
    send(8'h05, 4'd4, 8'h70);
    e0 = n_err; w0 = nwr;
    send(8'h47, 4'd8, 8'h80);
    chk("R5 seq error irq", n_err - e0, 1);
    chk("R11 no write on error", nwr - w0, 0);
    chk("R11 count cleared", int'(sts_count), 0);
    send(8'h46, 4'd2, 8'h90);
    chk("R11 pointer back to start", int'(tmem[20]), 8'h91);

    // R3 short frames, R2 DLC above 8
    w0 = nwr; e0 = n_err;
    send(8'h47, 4'd1, 8'hA0);
    send(8'h47, 4'd0, 8'hA0);
    chk("R3 short frames no write", nwr - w0, 0);
    send(8'h47, 4'd2, 8'hA0);
    chk("R3 sequence not advanced", n_err - e0, 0);
    chk("R3 next data", int'(tmem[21]), 8'hA1);
    send(8'h48, 4'd15, 8'hB0);
    for (int a = 22; a <= 28; a++) chk("R2 dlc clamp", int'(tmem[a]), 8'hB0 + a - 21);
    chk("R2 count", int'(sts_count), 9);

    // R4 reserved type ignored
    w0 = nwr; e0 = n_err;
    send(8'hC9, 4'd8, 8'hC0);
    chk("R4 reserved no write", nwr - w0, 0);
    send(8'h49, 4'd2, 8'hC0);
    chk("R4 reserved no effect", n_err - e0, 0);
    chk("R4 after reserved", int'(tmem[29]), 8'hC1);

    // R6 toggle mode
    load(2'b10, 1, 0, 63);
    m = nwr; d0 = n_done; e0 = n_err;
    send(8'h00, 4'd4, 8'h10);
    chk("R6 no start marker", int'(wlog_a[m]), 1);
    send(8'h10, 4'd3, 8'h20);
    send(8'h01, 4'd2, 8'h30);
    chk("R6 no error", n_err - e0, 0);
    chk("R6 done", n_done - d0, 1);
    chk("R6 count", int'(tmem[0]), 6);
    chk("R6 data", int'(tmem[5]), 8'h22);
    send(8'h10, 4'd2, 8'h40);
    chk("R6 toggled ok", n_err - e0, 0);
    send(8'h10, 4'd2, 8'h50);
    chk("R6 repeat toggle error", n_err - e0, 1);

    // R7 no-last mode, R10 buffer full
    load(2'b11, 1, 3, 10);
    d0 = n_done; f0 = n_full;
    send(8'h03, 4'd8, 8'h10);
    send(8'h04, 4'd8, 8'h50);
    chk("R10 full irq", n_full - f0, 1);
    chk("R7 no done", n_done - d0, 0);
    chk("R10 count at base", int'(tmem[0]), 9);
    chk("R10 last stored", int'(tmem[9]), 8'h52);
    chk("R10 rest dropped", int'(tmem[10] == 8'h53), 0);
    w0 = nwr;
    send(8'h05, 4'd4, 8'h60);
    chk("R10 halted", nwr - w0, 0);
    load(2'b11, 1, 3, 63);
    e0 = n_err;
    send(8'h00, 4'd3, 8'h10);
    chk("R7 first frame checked", n_err - e0, 1);
    d0 = n_done;
    send(8'h83, 4'd2, 8'h70);
    chk("R7 type bits ignored", n_done - d0, 0);
    chk("R7 data", int'(tmem[1]), 8'h71);

    // R8 plain mode
    load(2'b00, 30, 0, 63);
    e0 = n_err; d0 = n_done;
    send(8'h80, 4'd3, 8'h70);
    send(8'h80, 4'd2, 8'h80);
    chk("R8 no error", n_err - e0, 0);
    chk("R8 no done", n_done - d0, 0);
    chk("R8 data a", int'(tmem[31]), 8'h72);
    chk("R8 data b", int'(tmem[32]), 8'h81);

    // R10 completion wins; full in sequence mode; R12 reload
    load(2'b01, 1, 0, 8);
    d0 = n_done; f0 = n_full;
    send(8'h00, 4'd4, 8'h10);
    send(8'h81, 4'd5, 8'h20);
    chk("R10 completion wins done", n_done - d0, 1);
    chk("R10 completion wins full", n_full - f0, 0);
    chk("R10 completion count", int'(tmem[0]), 7);
    send(8'h00, 4'd8, 8'h30);
    chk("R10 seq full", n_full - f0, 1);
    w0 = nwr;
    send(8'h41, 4'd2, 8'h40);
    chk("R10 seq halted", nwr - w0, 0);
    load(2'b01, 1, 0, 63);
    chk("R12 count cleared", int'(sts_count), 0);
    send(8'h00, 4'd2, 8'h40);
    chk("R12 halt cleared", int'(tmem[1]), 8'h41);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule